// File: doc/BRIEF.md
# Timer Host Bus Interface and Command Decoder

This block sits between an 8-bit host bus and the three channels of a programmable interval timer. The host sees four byte locations. Addresses 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Address 3 is a command register that can only be written. The block samples the asynchronous bus into the system clock domain. It acts on each write or read once, on the trailing edge of the strobe. It turns every access into one-cycle strobes for the per-channel register units.

A byte written to address 3 is one of three kinds of command. The kind is chosen by fields inside the byte:
- a mode program for one channel;
- a count-latch request for one channel;
- a read-back request. This can latch the count, the status, or both, for any subset of the channels in one write. Its request bits are active low.

On reads, the block routes the addressed channel's current output byte onto the bus. It drives the bus only while the access is selected.

Top module: `tmr_host_if`

## Requirements
- R1: While reset is held and after its release with an idle bus, every strobe output is 0, `bus_rdata_oe` is 0 and `bus_rdata` is 0.
- R2: A write with `cs_n` low to address 0, 1 or 2 produces exactly one pulse on bit 0, 1 or 2 of `cnt_wr_stb`, respectively, with `wr_byte` equal to the written byte; nothing else pulses.
- R3: While `cs_n` is high, toggling `wr_n` or `rd_n` produces no strobe and leaves `bus_rdata_oe` at 0.
- R4: A write to address 3 whose bits [7:6] hold a channel number c in 0..2 and whose bits [5:4] are not 00 produces one pulse on `mode_stb[c]`, with `mode_word` equal to bits [5:0] of the byte.
- R5: A write to address 3 with bits [7:6] = c in 0..2 and bits [5:4] = 00 produces one pulse on `cnt_latch_stb[c]` and no `mode_stb` pulse.
- R6: A write to address 3 with bits [7:6] = 11 and bit 0 = 0 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 pulses `cnt_latch_stb` for every selected channel. Bit 4 = 0 pulses `sts_latch_stb` for every selected channel. Both kinds may pulse in the same cycle.
- R7: A read-back byte with bit 0 = 1 produces no strobe.
- R8: While `cs_n` and `rd_n` are low with address c in 0..2, `bus_rdata_oe` is 1 and `bus_rdata` equals byte c of `ch_rdata` (channel c in bits [8c+7:8c]). When `rd_n` rises, `cnt_rd_stb[c]` pulses once.
- R9: A read of address 3 leaves `bus_rdata_oe` at 0 and `bus_rdata` at 0, and produces no strobe.
- R10: Every strobe output is high for exactly one clock cycle per bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Location select: 0..2 channel, 3 command |
| bus_wdata | input | 8 | Byte written by the host |
| bus_rdata | output | 8 | Byte returned to the host, 0 when not driven |
| bus_rdata_oe | output | 1 | Bus drive enable for `bus_rdata` |
| ch_rdata | input | 24 | Current output byte of each channel, channel c in bits [8c+7:8c] |
| cnt_wr_stb | output | 3 | Per-channel count byte write pulse |
| wr_byte | output | 8 | Byte carried with `cnt_wr_stb` |
| mode_stb | output | 3 | Per-channel mode program pulse |
| mode_word | output | 6 | Access, mode and number-format field carried with `mode_stb` |
| cnt_latch_stb | output | 3 | Per-channel count latch pulse |
| sts_latch_stb | output | 3 | Per-channel status latch pulse |
| cnt_rd_stb | output | 3 | Per-channel read completion pulse |

## Verification
The bench aims at the field boundaries inside a command byte:
- An access field of 00 must be taken as a latch. A decoder that missed this would reprogram the channel's mode instead.
- Read-back request bits are active low. A decoder with the polarity inverted would latch the opposite kind of data.
- Read-back channel bits run from bit 1 upward. A decoder that got this wrong would latch the wrong channels.
- A read-back with its reserved bit set must do nothing. A decoder that ignored this bit would latch anyway.

Further tests check that:
- a write acts once, at its trailing edge, so a level-sensitive decoder that pulses on every cycle the strobe is low is caught;
- deselected accesses and reads of the command address never drive the bus or pulse a strobe;
- the read mux returns each channel's own byte, not a neighbour's.

// File: rtl/tmr_host_pkg.sv
// Package: shared constants and the sampled-bus type for the timer host interface.
// Assumes a fixed four-location address map: three channels plus one command location.
package tmr_host_pkg;

    localparam int NUM_CH   = 3;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam int MODE_W   = 6;
    localparam logic [ADDR_W-1:0] CMD_ADDR = 2'b11;
    localparam logic [1:0]        RB_SEL   = 2'b11;

    // One sample of the asynchronous host bus
    typedef struct packed {
        logic              cs_n;
        logic              rd_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_smp_t;

    localparam bus_smp_t IDLE_SMP = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                      addr: '0, data: '0};

endpackage

// File: rtl/tmr_bus_sync.sv
// Module: synchronises the host bus into the clock domain and flags the
// trailing edge of each selected write and read.
// Assumes address and data are stable while the strobe is low and one
// sample beyond its rising edge, and that chip select stays low across it.
module tmr_bus_sync
    import tmr_host_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t raw,
    output bus_smp_t cur,
    output bus_smp_t prev,
    output logic     wr_done,
    output logic     rd_done
);

    localparam int DEPTH = STAGES + 1;

    bus_smp_t pipe [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First sampling flop of the whole bus bundle
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= IDLE_SMP;
                    else        pipe[g] <= raw;
                end
            end else begin : g_next
                // Further synchroniser stage, last one is the edge-detect history
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= IDLE_SMP;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign cur  = pipe[STAGES-1];
    assign prev = pipe[STAGES];

    // Trailing edge of a strobe that was low while the chip was selected
    assign wr_done = !prev.cs_n && !prev.wr_n && cur.wr_n;
    assign rd_done = !prev.cs_n && !prev.rd_n && cur.rd_n;

endmodule

// File: rtl/tmr_cmd_decode.sv
// Module: turns completed bus accesses into registered one-cycle strobes.
// Decodes the command location into mode program, single-channel count
// latch, or multi-channel read-back with active-low request bits.
// Assumes smp holds the bus values captured while the strobe was low.
module tmr_cmd_decode
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic              rd_done,
    input  bus_smp_t          smp,
    output logic [NUM_CH-1:0] cnt_wr_stb,
    output logic [DATA_W-1:0] wr_byte,
    output logic [NUM_CH-1:0] mode_stb,
    output logic [MODE_W-1:0] mode_word,
    output logic [NUM_CH-1:0] cnt_latch_stb,
    output logic [NUM_CH-1:0] sts_latch_stb,
    output logic [NUM_CH-1:0] cnt_rd_stb
);

    logic [NUM_CH-1:0] nx_wr, nx_md, nx_cl, nx_sl, nx_rd;
    logic [DATA_W-1:0] nx_byte;
    logic [MODE_W-1:0] nx_word;
    logic [1:0]        sel;
    logic              is_cmd;

    assign sel    = smp.data[7:6];
    assign is_cmd = (smp.addr == CMD_ADDR);

    // Next-cycle strobes and payloads from the completed access
    always_comb begin
        nx_wr   = '0;
        nx_md   = '0;
        nx_cl   = '0;
        nx_sl   = '0;
        nx_rd   = '0;
        nx_byte = wr_byte;
        nx_word = mode_word;
        if (wr_done) begin
            if (!is_cmd) begin
                for (int i = 0; i < NUM_CH; i++)
                    nx_wr[i] = (smp.addr == ADDR_W'(i));
                nx_byte = smp.data;
            end else if (sel != RB_SEL) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (sel == 2'(i)) begin
                        nx_cl[i] = (smp.data[5:4] == 2'b00);
                        nx_md[i] = (smp.data[5:4] != 2'b00);
                    end
                end
                if (smp.data[5:4] != 2'b00) nx_word = smp.data[MODE_W-1:0];
            end else if (!smp.data[0]) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    nx_cl[i] = !smp.data[5] && smp.data[1+i];
                    nx_sl[i] = !smp.data[4] && smp.data[1+i];
                end
            end
        end
        if (rd_done && !is_cmd) begin
            for (int i = 0; i < NUM_CH; i++)
                nx_rd[i] = (smp.addr == ADDR_W'(i));
        end
    end

    // Register the strobes and hold the payloads between accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_wr_stb    <= '0;
            mode_stb      <= '0;
            cnt_latch_stb <= '0;
            sts_latch_stb <= '0;
            cnt_rd_stb    <= '0;
            wr_byte       <= '0;
            mode_word     <= '0;
        end else begin
            cnt_wr_stb    <= nx_wr;
            mode_stb      <= nx_md;
            cnt_latch_stb <= nx_cl;
            sts_latch_stb <= nx_sl;
            cnt_rd_stb    <= nx_rd;
            wr_byte       <= nx_byte;
            mode_word     <= nx_word;
        end
    end

endmodule

// File: rtl/tmr_rd_mux.sv
// Module: selects the addressed channel's output byte for the host bus.
// Drives only for a selected read of a channel location; otherwise outputs 0.
// Assumes cur is the synchronised bus sample.
module tmr_rd_mux
    import tmr_host_pkg::*;
(
    input  bus_smp_t                 cur,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_oe
);

    logic [NUM_CH-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
            assign hit[g] = (cur.addr == ADDR_W'(g));
        end
    endgenerate

    assign rdata_oe = !cur.cs_n && !cur.rd_n && (|hit);

    // AND-OR mux of the channel bytes, gated by the drive enable
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (hit[i] && rdata_oe) rdata = rdata | ch_rdata[i*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/tmr_host_if.sv
// Module: top of the timer host interface. Samples the host bus, decodes
// writes and commands into per-channel strobes, and muxes read data back.
// Assumes a free-running clock several times faster than the bus strobes.
module tmr_host_if
    import tmr_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_rdata_oe,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
    output logic [NUM_CH-1:0]        cnt_wr_stb,
    output logic [DATA_W-1:0]        wr_byte,
    output logic [NUM_CH-1:0]        mode_stb,
    output logic [MODE_W-1:0]        mode_word,
    output logic [NUM_CH-1:0]        cnt_latch_stb,
    output logic [NUM_CH-1:0]        sts_latch_stb,
    output logic [NUM_CH-1:0]        cnt_rd_stb
);

    bus_smp_t raw, cur, prev;
    logic     wr_done, rd_done;

    assign raw = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, addr: addr, data: bus_wdata};

    tmr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw),
        .cur     (cur),
        .prev    (prev),
        .wr_done (wr_done),
        .rd_done (rd_done)
    );

    tmr_cmd_decode u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_done       (wr_done),
        .rd_done       (rd_done),
        .smp           (prev),
        .cnt_wr_stb    (cnt_wr_stb),
        .wr_byte       (wr_byte),
        .mode_stb      (mode_stb),
        .mode_word     (mode_word),
        .cnt_latch_stb (cnt_latch_stb),
        .sts_latch_stb (sts_latch_stb),
        .cnt_rd_stb    (cnt_rd_stb)
    );

    tmr_rd_mux u_mux (
        .cur      (cur),
        .ch_rdata (ch_rdata),
        .rdata    (bus_rdata),
        .rdata_oe (bus_rdata_oe)
    );

endmodule

// File: rtl/tmr_host_if_chk.sv
// Checker: temporal properties of the timer host interface ports, bound to the top.
module tmr_host_if_chk
    import tmr_host_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              bus_rdata_oe,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] cnt_wr_stb,
    input logic [NUM_CH-1:0] mode_stb,
    input logic [NUM_CH-1:0] cnt_latch_stb,
    input logic [NUM_CH-1:0] sts_latch_stb,
    input logic [NUM_CH-1:0] cnt_rd_stb
);

    localparam int QUIET_LIM = 5;

    logic [2:0] cs_hi_run;

    // Count consecutive cycles with the chip deselected, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            cs_hi_run <= '0;
        else if (!cs_n)        cs_hi_run <= '0;
        else if (cs_hi_run != 3'(QUIET_LIM)) cs_hi_run <= cs_hi_run + 3'd1;
    end

    AST_WR_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cnt_wr_stb)); // R2
    AST_CS_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) (cs_hi_run == 3'(QUIET_LIM)) |-> (!bus_rdata_oe && cnt_wr_stb == '0 && mode_stb == '0 && cnt_latch_stb == '0 && sts_latch_stb == '0 && cnt_rd_stb == '0)); // R3
    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mode_stb)); // R4
    AST_LATCH_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n) (|cnt_latch_stb) |-> (mode_stb == '0 && cnt_wr_stb == '0)); // R5
    AST_STS_RB_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (|sts_latch_stb) |-> (mode_stb == '0 && cnt_wr_stb == '0 && cnt_rd_stb == '0)); // R6
    AST_RD_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cnt_rd_stb)); // R8
    AST_NO_DRIVE:    assert property (@(posedge clk) disable iff (!rst_n) !bus_rdata_oe |-> (bus_rdata == '0)); // R9
    AST_WR_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) (|cnt_wr_stb) |=> (cnt_wr_stb == '0)); // R10
    AST_MODE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) (|mode_stb) |=> (mode_stb == '0)); // R10
    AST_RD_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) (|cnt_rd_stb) |=> (cnt_rd_stb == '0)); // R10

endmodule

bind tmr_host_if tmr_host_if_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .bus_rdata_oe  (bus_rdata_oe),
    .bus_rdata     (bus_rdata),
    .cnt_wr_stb    (cnt_wr_stb),
    .mode_stb      (mode_stb),
    .cnt_latch_stb (cnt_latch_stb),
    .sts_latch_stb (sts_latch_stb),
    .cnt_rd_stb    (cnt_rd_stb)
);

// File: tb/tmr_host_if_bench.sv
// Bench: table of command/data writes with expected strobe masks, then
// directed tests for reset, deselect, reads and the command location.
module tmr_host_if_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] a;
        logic [7:0] d;
        logic [2:0] wr;
        logic [2:0] md;
        logic [2:0] cl;
        logic [2:0] sl;
        logic [7:0] w;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h12, 3'b001, 3'b000, 3'b000, 3'b000, 8'h12}, // R2
        '{2'd2, 8'hEE, 3'b100, 3'b000, 3'b000, 3'b000, 8'hEE}, // R2
        '{2'd3, 8'h34, 3'b000, 3'b001, 3'b000, 3'b000, 8'h34}, // R4
        '{2'd3, 8'h96, 3'b000, 3'b100, 3'b000, 3'b000, 8'h16}, // R4
        '{2'd3, 8'h40, 3'b000, 3'b000, 3'b010, 3'b000, 8'h00}, // R5
        '{2'd3, 8'hC2, 3'b000, 3'b000, 3'b001, 3'b001, 8'h00}, // R6
        '{2'd3, 8'hEC, 3'b000, 3'b000, 3'b000, 3'b110, 8'h00}, // R6
        '{2'd3, 8'hDE, 3'b000, 3'b000, 3'b111, 3'b000, 8'h00}, // R6
        '{2'd3, 8'hC3, 3'b000, 3'b000, 3'b000, 3'b000, 8'h00}, // R7
        '{2'd3, 8'hF0, 3'b000, 3'b000, 3'b000, 3'b000, 8'h00}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic [23:0] ch_rdata = {8'hC3, 8'h5A, 8'h3C};
    logic [2:0]  cnt_wr_stb, mode_stb, cnt_latch_stb, sts_latch_stb, cnt_rd_stb;
    logic [7:0]  wr_byte;
    logic [5:0]  mode_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int c_wr[3], c_md[3], c_cl[3], c_sl[3], c_rd[3];
    logic [7:0] cap_byte;
    logic [5:0] cap_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_host_if u_tmr_host_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdata_oe(bus_rdata_oe), .ch_rdata(ch_rdata),
        .cnt_wr_stb(cnt_wr_stb), .wr_byte(wr_byte), .mode_stb(mode_stb),
        .mode_word(mode_word), .cnt_latch_stb(cnt_latch_stb),
        .sts_latch_stb(sts_latch_stb), .cnt_rd_stb(cnt_rd_stb)
    );

    // Count strobe-high cycles and capture payloads, away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (cnt_wr_stb[i])    c_wr[i]++;
            if (mode_stb[i])      c_md[i]++;
            if (cnt_latch_stb[i]) c_cl[i]++;
            if (sts_latch_stb[i]) c_sl[i]++;
            if (cnt_rd_stb[i])    c_rd[i]++;
        end
        if (|cnt_wr_stb) cap_byte = wr_byte;
        if (|mode_stb)   cap_word = mode_word;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 3; i++) begin
            c_wr[i] = 0; c_md[i] = 0; c_cl[i] = 0; c_sl[i] = 0; c_rd[i] = 0;
        end
    endtask

    function automatic logic [2:0] mask_of(input int c0, input int c1, input int c2);
        return {c2 != 0, c1 != 0, c0 != 0};
    endfunction

    function automatic bit all_single();
        for (int i = 0; i < 3; i++)
            if (c_wr[i] > 1 || c_md[i] > 1 || c_cl[i] > 1 || c_sl[i] > 1 || c_rd[i] > 1) return 1'b0;
        return 1'b1;
    endfunction

    task automatic bus_write(input logic sel_n, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = sel_n; addr = a; bus_wdata = d; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_read(input logic sel_n, input logic [1:0] a, output logic oe, output logic [7:0] q);
        @(negedge clk);
        cs_n = sel_n; addr = a; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        oe = bus_rdata_oe; q = bus_rdata;
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1..all) actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic oe;
        logic [7:0] q;
        string tag;
        clear_counts();
        // R1: reset state
        repeat (3) @(negedge clk);
        check(bus_rdata_oe == 1'b0 && bus_rdata == 8'h00, "R1 in reset bus", {23'd0, bus_rdata_oe, bus_rdata}, 32'h0);
        check({cnt_wr_stb, mode_stb, cnt_latch_stb, sts_latch_stb, cnt_rd_stb} == '0, "R1 in reset strobes",
              {cnt_wr_stb, mode_stb, cnt_latch_stb, sts_latch_stb, cnt_rd_stb}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_rdata_oe == 1'b0 && wr_byte == 8'h00 && mode_word == 6'h00, "R1 after release",
              {bus_rdata_oe, wr_byte, mode_word}, 32'h0);

        // Table of writes: R2 R4 R5 R6 R7 with R10 pulse width
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].a != 2'd3)               tag = "R2";
            else if (VECS[v].d[7:6] != 2'b11)    tag = (VECS[v].d[5:4] == 2'b00) ? "R5" : "R4";
            else                                 tag = VECS[v].d[0] ? "R7" : "R6";
            clear_counts();
            bus_write(1'b0, VECS[v].a, VECS[v].d);
            check(mask_of(c_wr[0], c_wr[1], c_wr[2]) == VECS[v].wr, {tag, " cnt_wr_stb"}, mask_of(c_wr[0], c_wr[1], c_wr[2]), VECS[v].wr);
            check(mask_of(c_md[0], c_md[1], c_md[2]) == VECS[v].md, {tag, " mode_stb"}, mask_of(c_md[0], c_md[1], c_md[2]), VECS[v].md);
            check(mask_of(c_cl[0], c_cl[1], c_cl[2]) == VECS[v].cl, {tag, " cnt_latch_stb"}, mask_of(c_cl[0], c_cl[1], c_cl[2]), VECS[v].cl);
            check(mask_of(c_sl[0], c_sl[1], c_sl[2]) == VECS[v].sl, {tag, " sts_latch_stb"}, mask_of(c_sl[0], c_sl[1], c_sl[2]), VECS[v].sl);
            check(all_single(), "R10 single-cycle strobe", 32'd0, 32'd1);
            if (VECS[v].wr != 3'b000) check(cap_byte == VECS[v].w, "R2 wr_byte", cap_byte, VECS[v].w);
            if (VECS[v].md != 3'b000) check({2'b00, cap_word} == VECS[v].w, "R4 mode_word", cap_word, VECS[v].w);
        end

        // R3: deselected write and read do nothing
        clear_counts();
        bus_write(1'b1, 2'd1, 8'h77);
        bus_write(1'b1, 2'd3, 8'h10);
        bus_read(1'b1, 2'd0, oe, q);
        check(oe == 1'b0, "R3 oe deselected", oe, 0);
        check(mask_of(c_wr[0], c_wr[1], c_wr[2]) == 0 && mask_of(c_md[0], c_md[1], c_md[2]) == 0 &&
              mask_of(c_rd[0], c_rd[1], c_rd[2]) == 0, "R3 no strobes",
              {mask_of(c_wr[0], c_wr[1], c_wr[2]), mask_of(c_md[0], c_md[1], c_md[2]), mask_of(c_rd[0], c_rd[1], c_rd[2])}, 0);

        // R8: reads of each channel
        for (int c = 0; c < 3; c++) begin
            clear_counts();
            bus_read(1'b0, 2'(c), oe, q);
            check(oe == 1'b1, "R8 oe", oe, 1);
            check(q == ch_rdata[c*8 +: 8], "R8 read byte", q, ch_rdata[c*8 +: 8]);
            check(mask_of(c_rd[0], c_rd[1], c_rd[2]) == 3'(1 << c), "R8 cnt_rd_stb",
                  mask_of(c_rd[0], c_rd[1], c_rd[2]), 3'(1 << c));
            check(all_single(), "R10 read strobe width", 32'd0, 32'd1);
        end

        // R9: read of the command location
        clear_counts();
        bus_read(1'b0, 2'd3, oe, q);
        check(oe == 1'b0 && q == 8'h00, "R9 no drive", {oe, q}, 0);
        check(mask_of(c_rd[0], c_rd[1], c_rd[2]) == 0 && mask_of(c_cl[0], c_cl[1], c_cl[2]) == 0,
              "R9 no strobe", mask_of(c_rd[0], c_rd[1], c_rd[2]), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule